// File: doc/BRIEF.md
# Dual-Threshold Supply Monitor Back End

This block turns raw comparator decisions from a bank of supply-voltage monitor channels into clean, registered status bits for downstream sequencing logic. Each channel delivers two comparator results, one for each of two independently placed thresholds (called A and B here). Every raw bit first crosses into the master clock domain through a two-flop synchronizer. Each channel can then use comparator A on its own as a simple above/below test, or combine it with comparator B into an in-window test that is true only while the supply sits between the two thresholds.

Each resulting status bit then passes through an optional persistence filter. When the filter is enabled, a new level reaches the output only after it has held without interruption for a programmable number of master-clock cycles. The default is 512 cycles, which is 64 µs at 8 MHz. A shorter excursion is discarded, and any bounce restarts the count. When the filter is disabled, the synchronized level is registered straight through. Window mode and filter enable are static configuration inputs, set per channel.

Top module: `supmon_top`

## Requirements
- R1: While reset is asserted, and on the first sampled cycle after it, every status output is 0 and every persistence counter is cleared. A change that follows reset therefore needs the full hold time.
- R2: With the filter disabled, a change on a raw comparator input appears on the matching status output exactly 3 clock edges after it is applied: two synchronizer stages plus one output register.
- R3: In level mode (win_mode bit = 0), stat_a follows comparator A and ignores comparator B.
- R4: In window mode (win_mode bit = 1), stat_a equals A AND NOT B. It is 1 only when A is asserted and B is not.
- R5: stat_b always follows comparator B, whatever the channel's mode.
- R6: With the filter enabled (filt_en bit = 1), a status output takes a new value only after its synchronized input has differed from it on FILT_LEN consecutive edges. End to end, that is FILT_LEN+2 edges after the raw change.
- R7: With the filter enabled, an excursion held for fewer than FILT_LEN cycles leaves the output unchanged. Once the input returns to the output value, the count restarts from zero.
- R8: Each channel's configuration and inputs affect only that channel's outputs.
- R9: A persistence counter never reaches FILT_LEN.
- R10: Clearing a channel's filt_en bit makes the output follow its synchronized input on the next edge and clears any partial count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_a | input | NUM_CH | Raw comparator A result per channel (asynchronous) |
| cmp_b | input | NUM_CH | Raw comparator B result per channel (asynchronous) |
| win_mode | input | NUM_CH | Per channel: 0 = level mode, 1 = window mode |
| filt_en | input | NUM_CH | Per channel: 1 = persistence filter active |
| stat_a | output | NUM_CH | Registered status A per channel |
| stat_b | output | NUM_CH | Registered status B per channel |

## Verification
Two events can land on the same edge. The first is the terminal cycle of the hold count. The second is either the input returning to the held value or the filter being switched off. The bench provokes the first case with an excursion lasting exactly FILT_LEN-1 cycles, and with a one-cycle dip part-way through a hold. It judges the result by the exact edge on which the output moves, or by the output not moving at all. The bench provokes the second case by clearing filt_en in the middle of a count, then expects the output to follow on the very next edge and a later change to need the full hold again. A sweep over every mode, filter setting and comparator pair, rotated across channels, checks the steady-state window logic and the separation between channels.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    typedef enum logic {
        MODE_LEVEL  = 1'b0,
        MODE_WINDOW = 1'b1
    } win_mode_e;

    typedef struct packed {
        logic hi;   // threshold A decision
        logic lo;   // threshold B decision
    } cmp_pair_t;

    // Combine a comparator pair into status A according to the mode.
    function automatic logic combine_a(win_mode_e mode, cmp_pair_t p);
        if (mode == MODE_WINDOW) begin
            return p.hi & ~p.lo;
        end
        return p.hi;
    endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/supmon_window.sv
module supmon_window
    import supmon_pkg::*;
#(
    parameter int NUM_CH = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] mode,
    input  logic [NUM_CH-1:0] a_in,
    input  logic [NUM_CH-1:0] b_in,
    output logic [NUM_CH-1:0] a_out,
    output logic [NUM_CH-1:0] b_out
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        cmp_pair_t pair;
        win_mode_e mode_e;

        assign pair   = '{hi: a_in[i], lo: b_in[i]};
        assign mode_e = win_mode_e'(mode[i]);
        assign a_out[i] = combine_a(mode_e, pair);
        assign b_out[i] = b_in[i];

        // R4
        win_block_chk: assert property (@(posedge clk) disable iff (rst)
            (mode[i] && b_in[i]) |-> !a_out[i]);
    end
endmodule

// File: rtl/supmon_filt_bit.sv
module supmon_filt_bit #(
    parameter int FILT_LEN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
            cnt  <= '0;
        end else if (!en) begin
            dout <= din;
            cnt  <= '0;
        end else if (din == dout) begin
            cnt  <= '0;
        end else if (cnt == LAST) begin
            dout <= din;
            cnt  <= '0;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R10
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (dout == $past(din)));

    // R6
    filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != LAST) |=> $stable(dout));

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (dout == 1'b0 && cnt == '0));
endmodule

// File: rtl/supmon_top.sv
module supmon_top
    import supmon_pkg::*;
#(
    parameter int NUM_CH   = 10,
    parameter int FILT_LEN = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] cmp_a,
    input  logic [NUM_CH-1:0] cmp_b,
    input  logic [NUM_CH-1:0] win_mode,
    input  logic [NUM_CH-1:0] filt_en,
    output logic [NUM_CH-1:0] stat_a,
    output logic [NUM_CH-1:0] stat_b
);
    localparam int SYNC_W = 2 * NUM_CH;

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic [NUM_CH-1:0] sa, sb;
    logic [NUM_CH-1:0] wa, wb;

    assign raw_bus = {cmp_b, cmp_a};
    assign sa      = sync_bus[NUM_CH-1:0];
    assign sb      = sync_bus[SYNC_W-1:NUM_CH];

    supmon_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (sync_bus)
    );

    supmon_window #(.NUM_CH(NUM_CH)) u_window (
        .clk   (clk),
        .rst   (rst),
        .mode  (win_mode),
        .a_in  (sa),
        .b_in  (sb),
        .a_out (wa),
        .b_out (wb)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_filt
        supmon_filt_bit #(.FILT_LEN(FILT_LEN)) u_fa (
            .clk  (clk),
            .rst  (rst),
            .en   (filt_en[i]),
            .din  (wa[i]),
            .dout (stat_a[i])
        );
        supmon_filt_bit #(.FILT_LEN(FILT_LEN)) u_fb (
            .clk  (clk),
            .rst  (rst),
            .en   (filt_en[i]),
            .din  (wb[i]),
            .dout (stat_b[i])
        );
    end
endmodule

// File: tb/supmon_top_tb.sv
`timescale 1ns/1ps
module supmon_top_tb;
    localparam int NCH = 3;
    localparam int FL  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] cmp_a = '0, cmp_b = '0, win_mode = '0, filt_en = '1;
    logic [NCH-1:0] stat_a, stat_b;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    supmon_top #(.NUM_CH(NCH), .FILT_LEN(FL)) u_dut (
        .clk(clk), .rst(rst), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .win_mode(win_mode), .filt_en(filt_en),
        .stat_a(stat_a), .stat_b(stat_b)
    );

    task automatic step(int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        for (int i = 0; i < NCH; i++) begin
            chk("R1 stat_a reset", stat_a[i], 1'b0);
            chk("R1 stat_b reset", stat_b[i], 1'b0);
        end

        // R6 / R1: hold time right after reset, counter starts cleared
        cmp_a[0] = 1'b1;
        step(FL + 1);
        chk("R6 R1 before hold", stat_a[0], 1'b0);
        step(1);
        chk("R6 R1 after hold", stat_a[0], 1'b1);

        // R7: excursion one cycle short of the hold is discarded
        cmp_a[1] = 1'b1;
        step(FL - 1);
        cmp_a[1] = 1'b0;
        step(2 * FL);
        chk("R7 short pulse ignored", stat_a[1], 1'b0);

        // R7: a one-cycle dip restarts the count
        cmp_a[2] = 1'b1;
        step(FL - 2);
        cmp_a[2] = 1'b0;
        step(1);
        cmp_a[2] = 1'b1;
        step(FL + 1);
        chk("R7 restart before hold", stat_a[2], 1'b0);
        step(1);
        chk("R7 restart after hold", stat_a[2], 1'b1);

        // R10: disabling the filter mid-count passes the level on the next edge
        cmp_a[0] = 1'b0;
        step(4);
        chk("R10 still counting", stat_a[0], 1'b1);
        filt_en[0] = 1'b0;
        step(1);
        chk("R10 bypass immediate", stat_a[0], 1'b0);

        // R2: bypass latency of 3 edges
        cmp_a[0] = 1'b1;
        step(2);
        chk("R2 before latency", stat_a[0], 1'b0);
        step(1);
        chk("R2 at latency", stat_a[0], 1'b1);

        // R10: count was cleared, re-enabled filter needs full hold
        filt_en[0] = 1'b1;
        cmp_a[0] = 1'b0;
        step(FL + 1);
        chk("R10 R6 full hold before", stat_a[0], 1'b1);
        step(1);
        chk("R10 R6 full hold after", stat_a[0], 1'b0);

        // Sweep over configurations and comparator pairs, rotated per channel
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 4; p++) begin
                for (int i = 0; i < NCH; i++) begin
                    int cfg = (c + i) % 4;
                    int pt  = (p + i) % 4;
                    win_mode[i] = cfg[1];
                    filt_en[i]  = cfg[0];
                    cmp_a[i]    = pt[1];
                    cmp_b[i]    = pt[0];
                end
                step(FL + 4);
                for (int i = 0; i < NCH; i++) begin
                    int cfg = (c + i) % 4;
                    int pt  = (p + i) % 4;
                    logic ea;
                    ea = cfg[1] ? (pt[1] & ~pt[0]) : pt[1];
                    if (cfg[1])
                        chk("R4 R8 window stat_a", stat_a[i], ea);
                    else
                        chk("R3 R8 level stat_a", stat_a[i], ea);
                    chk("R5 R8 stat_b", stat_b[i], pt[0]);
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule